// File: doc/BRIEF.md
# Six-Control-Bit Sixteen-Bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a small 16-bit datapath. It takes two operands and six independent control bits. Each operand can first be cleared to zero and then inverted. The two conditioned operands are then either ANDed bit by bit or added through a ripple carry chain. The chosen value can be inverted on its way out. These few primitives are enough to build move, NOT, clear, NAND, NOR, OR and subtraction.

A separate load-immediate select bypasses the arithmetic. When it is set, the result is the low 15 bits of an instruction word, with the top bit driven to 0. A zero flag and a sign flag are taken from the final result. A carry flag comes straight from the adder.

The block has no clock, no state and no handshake. Every output follows its inputs within the same cycle of whatever logic surrounds it.

Top module: `sixctl_alu`

## Requirements
- R1: Each operand is conditioned in two steps: first cleared to all zeros when its zero control is 1, then bitwise inverted when its invert control is 1. Both controls set gives 16'hFFFF.
- R2: With `fn_add`=0 and `load_imm`=0, the pre-inversion value is the bitwise AND of the two conditioned operands.
- R3: With `fn_add`=1 and `load_imm`=0, the pre-inversion value is the low 16 bits of the unsigned sum of the two conditioned operands. The carry into bit 0 is 0. `carry_out` is bit 16 of that sum.
- R4: With `inv_out`=1 and `load_imm`=0, `result` is the bitwise inverse of the pre-inversion value. `carry_out` does not depend on `inv_out`.
- R5: `zero_flag` is 1 exactly when all 16 bits of `result` are 0.
- R6: `neg_flag` equals bit 15 of `result`.
- R7: With `load_imm`=1, `result` is `{1'b0, imm_word[14:0]}` regardless of the other controls and operands. `zero_flag` and `neg_flag` are computed from that value.
- R8: `inv_a`=1, `fn_add`=1, `inv_out`=1, with the other controls 0, gives `result` = `opa - opb` modulo 2^16.
- R9: `inv_a`=1, `inv_b`=1, `inv_out`=1, with the other controls 0, gives `result` = `opa | opb`.
- R10: The carry ripples across the full width. 16'hFFFF + 16'h0001 gives `result` 0 and `carry_out` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| zero_a | input | 1 | Clear first operand before its inversion step |
| inv_a | input | 1 | Invert the first operand after clearing |
| zero_b | input | 1 | Clear second operand before its inversion step |
| inv_b | input | 1 | Invert the second operand after clearing |
| fn_add | input | 1 | 1 selects the sum, 0 selects the bitwise AND |
| inv_out | input | 1 | Invert the selected value |
| load_imm | input | 1 | Output the 15-bit immediate in place of the computed value |
| imm_word | input | 16 | Instruction word whose low 15 bits form the immediate |
| result | output | 16 | Final output |
| carry_out | output | 1 | Carry out of bit 15 of the adder; meaningful only when fn_add is 1 |
| zero_flag | output | 1 | All result bits are zero |
| neg_flag | output | 1 | Result bit 15 |

## Verification
The hardest case to reach is a carry that must travel through every slice. Random operands almost never produce it, so the bench applies directed operands: all-ones plus one, and the both-controls-set forms that turn an operand into 16'hFFFF. These are run alongside a sweep of all 64 combinations of the six controls, each with several random operand pairs. For each case, the bench compares the result, the flags and, when the sum is selected, the carry against a reference model computed from wide integer arithmetic.

// File: rtl/sixctl_alu_pkg.sv
package sixctl_alu_pkg;
  typedef struct packed {
    logic zero_a;
    logic inv_a;
    logic zero_b;
    logic inv_b;
    logic fn_add;
    logic inv_out;
  } alu_ctl_t;
endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  logic         clr,
  input  logic         inv,
  output logic [W-1:0] dout
);
  // Complement-or-clear, then XNOR against the invert control.
  always_comb begin
    for (int i = 0; i < W; i++) begin
      dout[i] = ~((~din[i] | clr) ^ inv);
    end
  end
endmodule

// File: rtl/alu_fa_slice.sv
module alu_fa_slice (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic s,
  output logic cout
);
  logic hx;
  assign hx   = a ^ b;
  assign s    = hx ^ cin;
  assign cout = (a & b) | (hx & cin);
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;

  for (genvar g = 0; g < W; g++) begin : g_slice
    alu_fa_slice u_fa (
      .a   (a[g]),
      .b   (b[g]),
      .cin (chain[g]),
      .s   (sum[g]),
      .cout(chain[g+1])
    );
  end

  assign cout = chain[W];
endmodule

// File: rtl/sixctl_alu.sv
module sixctl_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         zero_a,
  input  logic         inv_a,
  input  logic         zero_b,
  input  logic         inv_b,
  input  logic         fn_add,
  input  logic         inv_out,
  input  logic         load_imm,
  input  logic [W-1:0] imm_word,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         zero_flag,
  output logic         neg_flag
);
  import sixctl_alu_pkg::*;

  localparam int IMM_W = W - 1;

  alu_ctl_t        ctl;
  logic [W-1:0]    a_c, b_c;
  logic [W-1:0]    sum_v, and_v, pre_v, post_v, imm_v;

  assign ctl = '{zero_a: zero_a, inv_a: inv_a, zero_b: zero_b,
                 inv_b: inv_b, fn_add: fn_add, inv_out: inv_out};

  alu_operand_cond #(.W(W)) u_cond_a (
    .din(opa), .clr(ctl.zero_a), .inv(ctl.inv_a), .dout(a_c)
  );

  alu_operand_cond #(.W(W)) u_cond_b (
    .din(opb), .clr(ctl.zero_b), .inv(ctl.inv_b), .dout(b_c)
  );

  alu_ripple_adder #(.W(W)) u_add (
    .a(a_c), .b(b_c), .sum(sum_v), .cout(carry_out)
  );

  assign and_v  = a_c & b_c;
  assign pre_v  = ctl.fn_add ? sum_v : and_v;
  assign post_v = pre_v ^ {W{ctl.inv_out}};
  assign imm_v  = {1'b0, imm_word[IMM_W-1:0]};
  assign result = load_imm ? imm_v : post_v;

  assign zero_flag = ~|result;
  assign neg_flag  = result[W-1];
endmodule

// File: rtl/sixctl_alu_chk.sv
module sixctl_alu_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         zero_a,
  input logic         inv_a,
  input logic         zero_b,
  input logic         inv_b,
  input logic         fn_add,
  input logic         inv_out,
  input logic         load_imm,
  input logic [W-1:0] imm_word,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         zero_flag,
  input logic         neg_flag
);
  logic move_b_ctl, clear_ctl, zsum_ctl;

  assign move_b_ctl = !load_imm && !fn_add && zero_a && inv_a
                      && !zero_b && !inv_b && !inv_out;
  assign clear_ctl  = !load_imm && !fn_add && zero_a && zero_b
                      && !inv_a && !inv_b && !inv_out;
  assign zsum_ctl   = zero_a && zero_b && !(inv_a && inv_b);

  always_comb begin
    a_r7_imm_path: assert (!load_imm ||
                           (result[W-1] == 1'b0 && result[W-2:0] == imm_word[W-2:0]))
      else $error("immediate path mismatch");
    a_r2_move_b: assert (!move_b_ctl || result == opb)
      else $error("move through AND with all ones failed");
    a_r1_clear: assert (!clear_ctl || (result == '0 && zero_flag))
      else $error("cleared operands did not give zero");
    a_r3_no_carry_zero_ops: assert (!zsum_ctl || !carry_out)
      else $error("carry from operands that cannot overflow");
    a_r5_flags_exclusive: assert (!zero_flag || !neg_flag)
      else $error("zero and negative flags both set");
  end
endmodule

bind sixctl_alu sixctl_alu_chk #(.W(W)) u_chk (
  .opa(opa), .opb(opb), .zero_a(zero_a), .inv_a(inv_a),
  .zero_b(zero_b), .inv_b(inv_b), .fn_add(fn_add), .inv_out(inv_out),
  .load_imm(load_imm), .imm_word(imm_word), .result(result),
  .carry_out(carry_out), .zero_flag(zero_flag), .neg_flag(neg_flag)
);

// File: tb/tb_sixctl_alu.sv
module tb_sixctl_alu;
  localparam int W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [W-1:0] opa, opb, imm_word, result;
  logic zero_a, inv_a, zero_b, inv_b, fn_add, inv_out, load_imm;
  logic carry_out, zero_flag, neg_flag;

  sixctl_alu #(.W(W)) dut (
    .opa(opa), .opb(opb), .zero_a(zero_a), .inv_a(inv_a),
    .zero_b(zero_b), .inv_b(inv_b), .fn_add(fn_add), .inv_out(inv_out),
    .load_imm(load_imm), .imm_word(imm_word), .result(result),
    .carry_out(carry_out), .zero_flag(zero_flag), .neg_flag(neg_flag)
  );

  typedef struct packed {
    logic [W-1:0] res;
    logic         cy;
    logic         chk_cy;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_cmp  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  // ctl bits: [5]=zero_a [4]=inv_a [3]=zero_b [2]=inv_b [1]=fn_add [0]=inv_out
  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [5:0] c, input logic li,
                       input logic [W-1:0] imm, input string tag);
    logic [W-1:0] xc, yc, pre;
    logic [W:0]   s;
    exp_t e;
    xc  = c[5] ? '0 : x;
    xc  = c[4] ? ~xc : xc;
    yc  = c[3] ? '0 : y;
    yc  = c[2] ? ~yc : yc;
    s   = {1'b0, xc} + {1'b0, yc};
    pre = c[1] ? s[W-1:0] : (xc & yc);
    pre = c[0] ? ~pre : pre;
    e.res    = li ? {1'b0, imm[W-2:0]} : pre;
    e.cy     = s[W];
    e.chk_cy = c[1];
    @(posedge clk);
    opa = x; opb = y; imm_word = imm; load_imm = li;
    {zero_a, inv_a, zero_b, inv_b, fn_add, inv_out} = c;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (result !== e.res || zero_flag !== (e.res == '0) ||
          neg_flag !== e.res[W-1] || (e.chk_cy && carry_out !== e.cy)) begin
        n_fail++;
        $display("FAIL %s: res=%h z=%b n=%b c=%b expected res=%h z=%b n=%b c=%b",
                 t, result, zero_flag, neg_flag, carry_out,
                 e.res, (e.res == '0), e.res[W-1], e.cy);
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin
    opa = '0; opb = '0; imm_word = '0;
    {zero_a, inv_a, zero_b, inv_b, fn_add, inv_out, load_imm} = '0;
    // idle state: all-zero inputs, AND of zeros
    drive(16'h0000, 16'h0000, 6'b000000, 1'b0, 16'h0, "R5 idle zero");
    // R1 conditioning corners
    drive(16'h1234, 16'hFFFF, 6'b100000, 1'b0, 16'h0, "R1 zero_a only");
    drive(16'h1234, 16'hFFFF, 6'b010000, 1'b0, 16'h0, "R1 inv_a only");
    drive(16'h1234, 16'hFFFF, 6'b110000, 1'b0, 16'h0, "R1 zero+inv gives ones");
    drive(16'hA5A5, 16'h00F0, 6'b001100, 1'b0, 16'h0, "R1 b ones AND");
    // R2 AND
    drive(16'hF0F0, 16'h3C3C, 6'b000000, 1'b0, 16'h0, "R2 and");
    // R3 add with and without carry
    drive(16'h1234, 16'h4321, 6'b000010, 1'b0, 16'h0, "R3 add");
    drive(16'h8000, 16'h8000, 6'b000010, 1'b0, 16'h0, "R3 add carry");
    // R4 output inversion, carry untouched
    drive(16'h8000, 16'h8001, 6'b000011, 1'b0, 16'h0, "R4 inv out add");
    drive(16'hFF00, 16'h0FF0, 6'b000001, 1'b0, 16'h0, "R4 nand");
    // R6 negative
    drive(16'h7FFF, 16'h0001, 6'b000010, 1'b0, 16'h0, "R6 neg from add");
    // R7 immediate
    drive(16'h1111, 16'h2222, 6'b000010, 1'b1, 16'hFFFF, "R7 imm top bit dropped");
    drive(16'h1111, 16'h2222, 6'b111111, 1'b1, 16'h8000, "R7 imm zero");
    drive(16'h0, 16'h0, 6'b000001, 1'b1, 16'h4ABC, "R7 imm over ones");
    // R8 subtract
    drive(16'd1000, 16'd1, 6'b010011, 1'b0, 16'h0, "R8 sub");
    drive(16'd5, 16'd9, 6'b010011, 1'b0, 16'h0, "R8 sub negative");
    // R9 or
    drive(16'hF000, 16'h000F, 6'b010101, 1'b0, 16'h0, "R9 or");
    // R10 full ripple
    drive(16'hFFFF, 16'h0001, 6'b000010, 1'b0, 16'h0, "R10 ripple all");
    drive(16'h0000, 16'h0000, 6'b110110, 1'b0, 16'h0, "R10 ones plus ones");
    drive(16'hFFFF, 16'h0000, 6'b000110, 1'b0, 16'h0, "R10 ones plus ones via b");
    // exhaustive control sweep with random operands
    for (int c = 0; c < 64; c++) begin
      for (int k = 0; k < 6; k++) begin
        drive(W'($urandom), W'($urandom), 6'(c), 1'b0, W'($urandom), "R1 R2 R3 R4 sweep");
      end
    end
    for (int k = 0; k < 20; k++) begin
      drive(W'($urandom), W'($urandom), 6'($urandom), 1'b1, W'($urandom), "R7 random imm");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule